// File: doc/BRIEF.md
# Parallel Port Control Pin Merger

This block keeps the host's 8-bit device control register and combines it with the requests from the port's handshake state machines. The result drives the three active-low control lines (strobe, autofeed, init) and the enable of the data-bus drivers. Software writes the register through a simple write strobe, and reads it back on a read bus that is always valid. The state machines present their own active-low strobe and autofeed requests. Either source can pull a line low.

The direction bit turns the data bus around only in the bidirectional and extended modes. In the plain standard mode (000) and in the FIFO-compatible mode (010), the drivers stay enabled whatever that bit holds. The register resets to all zeros, which means no override is active and the bus runs in the forward direction.

Top module: `pport_ctl_mux`

## Requirements
- R1: After reset the register reads 0x00, `dataDrvEn` is 1, `initLineN` is 1, and the strobe and feed lines equal the state-machine requests.
- R2: While register bit 0 is 1, `strbLineN` is 0 in every mode, whatever `smStrobeN` is.
- R3: While register bit 1 is 1, `feedLineN` is 0 in every mode, whatever `smFeedN` is.
- R4: While the matching override bit (bit 0 or bit 1) is 0, `strbLineN` follows `smStrobeN` and `feedLineN` follows `smFeedN`, in the same cycle.
- R5: `initLineN` is the inverse of register bit 2. Writing a 1 to bit 2 drives the line low, and writing a 0 drives it high.
- R6: `rdData[7:6]` always reads 0, even after ones are written to those bits.
- R7: `rdData[5:0]` returns the bits 5:0 of the last write.
- R8: In mode 000 or mode 010, `dataDrvEn` is 1 whatever the value of bit 5 (the direction bit).
- R9: In any other mode, `dataDrvEn` is 0 when bit 5 is 1 (reverse, the bus is read from the peripheral) and 1 when bit 5 is 0.
- R10: A write with `wrEn` high is visible on `rdData` and on the pins right after that rising edge. With `wrEn` low, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write value |
| rdData | output | 8 | Register readback value |
| portMode | input | 3 | Current port mode |
| smStrobeN | input | 1 | Active-low strobe request from the state machines |
| smFeedN | input | 1 | Active-low autofeed request from the state machines |
| strbLineN | output | 1 | Strobe pin level, active low |
| feedLineN | output | 1 | Autofeed pin level, active low |
| initLineN | output | 1 | Init pin level, active low |
| dataDrvEn | output | 1 | Data driver enable (1 drives the bus forward) |

## Verification
The register is the only sequential stage. A write therefore shows up on `rdData` and on every pin one clock edge after `wrEn` is sampled high. Changes on `portMode`, `smStrobeN` and `smFeedN` reach the pins in the same cycle, with no edge in between. The bench drives inputs on the falling edge. It checks register results at the next falling edge, after the single rising edge. It checks combinational results a short delay after the input change, so each check lands exactly where its result is due.

// File: rtl/pport_ctl_pkg.sv
package pport_ctl_pkg;
  parameter int REG_W = 8;
  parameter int MODE_W = 3;
  parameter int NUM_FORCE = 2;          // strobe, autofeed
  parameter int INIT_BIT = 2;
  parameter int DIR_BIT = 5;
  parameter int KEEP_W = 6;             // bits 5:0 are stored
  parameter logic [MODE_W-1:0] MODE_STD  = 3'b000;
  parameter logic [MODE_W-1:0] MODE_FIFO = 3'b010;

  typedef struct packed {
    logic loadReg;
    logic dirIgnore;
  } ctlStrobe_t;
endpackage

// File: rtl/pport_ctl_seq.sv
module pport_ctl_seq
  import pport_ctl_pkg::*;
(
  input  logic              wrEn,
  input  logic [MODE_W-1:0] portMode,
  output ctlStrobe_t        stb
);
  always_comb begin
    stb.loadReg   = wrEn;
    stb.dirIgnore = (portMode == MODE_STD) || (portMode == MODE_FIFO);
  end
endmodule

// File: rtl/pport_ctl_dp.sv
module pport_ctl_dp
  import pport_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           stb,
  input  logic [REG_W-1:0]     wrData,
  input  logic [NUM_FORCE-1:0] smReqN,
  output logic [REG_W-1:0]     rdData,
  output logic [NUM_FORCE-1:0] lineN,
  output logic                 initLineN,
  output logic                 dataDrvEn
);
  localparam int PAD_W = REG_W - KEEP_W;

  logic [KEEP_W-1:0] ctlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlReg <= '0;
    else if (stb.loadReg) ctlReg <= wrData[KEEP_W-1:0];
  end

  // either the register override or the state machine pulls a line low
  for (genvar i = 0; i < NUM_FORCE; i++) begin : g_force
    assign lineN[i] = smReqN[i] & ~ctlReg[i];
  end

  assign initLineN = ~ctlReg[INIT_BIT];
  assign dataDrvEn = stb.dirIgnore | ~ctlReg[DIR_BIT];
  assign rdData    = {{PAD_W{1'b0}}, ctlReg};
endmodule

// File: rtl/pport_ctl_mux.sv
module pport_ctl_mux
  import pport_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [MODE_W-1:0] portMode,
  input  logic             smStrobeN,
  input  logic             smFeedN,
  output logic             strbLineN,
  output logic             feedLineN,
  output logic             initLineN,
  output logic             dataDrvEn
);
  ctlStrobe_t stb;
  logic [NUM_FORCE-1:0] lineN;

  pport_ctl_seq u_seq (.wrEn(wrEn), .portMode(portMode), .stb(stb));

  pport_ctl_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .smReqN({smFeedN, smStrobeN}), .rdData(rdData), .lineN(lineN),
    .initLineN(initLineN), .dataDrvEn(dataDrvEn)
  );

  assign strbLineN = lineN[0];
  assign feedLineN = lineN[1];
endmodule

// File: rtl/pport_ctl_chk.sv
module pport_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [2:0] portMode,
  input logic       smStrobeN,
  input logic       smFeedN,
  input logic       strbLineN,
  input logic       feedLineN,
  input logic       initLineN,
  input logic       dataDrvEn
);
  assert_strobe_force_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] |-> !strbLineN);
  assert_feed_force_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdData[1] |-> !feedLineN);
  assert_low_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strbLineN || !feedLineN) |-> (rdData[0] || !smStrobeN || strbLineN) &&
                                   (rdData[1] || !smFeedN || feedLineN));
  assert_init_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    initLineN != rdData[2]);
  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7:6] == 2'b00);
  assert_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[5:0] == $past(wrData[5:0]));
  assert_compat_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
    (portMode == 3'b000 || portMode == 3'b010) |-> dataDrvEn);
  assert_reverse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (portMode != 3'b000 && portMode != 3'b010 && rdData[5]) |-> !dataDrvEn);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));
endmodule

bind pport_ctl_mux pport_ctl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .portMode(portMode), .smStrobeN(smStrobeN), .smFeedN(smFeedN),
  .strbLineN(strbLineN), .feedLineN(feedLineN), .initLineN(initLineN),
  .dataDrvEn(dataDrvEn)
);

// File: tb/pport_ctl_mux_tb.sv
module pport_ctl_mux_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [2:0] portMode = 3'b000;
  logic smStrobeN = 1'b1;
  logic smFeedN = 1'b1;
  logic strbLineN, feedLineN, initLineN, dataDrvEn;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] shadow = '0;

  always #2.5 clk = ~clk;

  pport_ctl_mux u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .portMode(portMode), .smStrobeN(smStrobeN), .smFeedN(smFeedN),
    .strbLineN(strbLineN), .feedLineN(feedLineN), .initLineN(initLineN),
    .dataDrvEn(dataDrvEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write lands at the rising edge; results sampled at the following falling edge
  task automatic regWrite(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'hxx;
    shadow = {2'b00, d[5:0]};
    #0.5;
  endtask

  task automatic setIn(input logic [2:0] m, input logic s, input logic f);
    portMode = m; smStrobeN = s; smFeedN = f;
    #0.5;
  endtask

  task automatic testReset;
    check("R1 rdData", rdData, 8'h00);
    check("R1 dataDrvEn", {7'b0, dataDrvEn}, 8'h01);
    check("R1 initLineN", {7'b0, initLineN}, 8'h01);
    check("R1 strbLineN", {7'b0, strbLineN}, 8'h01);
    setIn(3'b011, 1'b0, 1'b1);
    check("R1 strb follows", {7'b0, strbLineN}, 8'h00);
    setIn(3'b000, 1'b1, 1'b1);
  endtask

  task automatic testFollow;
    for (int k = 0; k < 4; k++) begin
      setIn(3'b011, k[0], k[1]);
      check("R4 strbLineN", {7'b0, strbLineN}, {7'b0, k[0]});
      check("R4 feedLineN", {7'b0, feedLineN}, {7'b0, k[1]});
    end
  endtask

  task automatic testForce;
    regWrite(8'h03);
    for (int m = 0; m < 8; m++) begin
      setIn(m[2:0], 1'b1, 1'b1);
      check("R2 strobe forced", {7'b0, strbLineN}, 8'h00);
      check("R3 feed forced", {7'b0, feedLineN}, 8'h00);
    end
    regWrite(8'h01);
    setIn(3'b011, 1'b1, 1'b0);
    check("R2 strobe forced only", {7'b0, strbLineN}, 8'h00);
    check("R4 feed from sm", {7'b0, feedLineN}, 8'h00);
    setIn(3'b011, 1'b1, 1'b1);
    check("R4 feed released", {7'b0, feedLineN}, 8'h01);
    regWrite(8'h02);
    check("R3 feed forced only", {7'b0, feedLineN}, 8'h00);
    check("R4 strobe released", {7'b0, strbLineN}, 8'h01);
  endtask

  task automatic testInit;
    regWrite(8'h04);
    check("R5 init low", {7'b0, initLineN}, 8'h00);
    regWrite(8'h00);
    check("R5 init high", {7'b0, initLineN}, 8'h01);
  endtask

  task automatic testReadback;
    regWrite(8'hFF);
    check("R6 R7 readback FF", rdData, shadow);
    check("R6 reserved zero", {6'b0, rdData[7:6]}, 8'h00);
    regWrite(8'h9A);
    check("R7 readback 9A", rdData, 8'h1A);
    regWrite(8'h55);
    check("R7 readback 55", rdData, 8'h15);
  endtask

  task automatic testDir;
    regWrite(8'h20);
    for (int m = 0; m < 8; m++) begin
      setIn(m[2:0], 1'b1, 1'b1);
      if (m == 0 || m == 2) check("R8 compat drive", {7'b0, dataDrvEn}, 8'h01);
      else check("R9 reverse", {7'b0, dataDrvEn}, 8'h00);
    end
    regWrite(8'h00);
    setIn(3'b001, 1'b1, 1'b1);
    check("R9 forward", {7'b0, dataDrvEn}, 8'h01);
  endtask

  task automatic testHold;
    regWrite(8'h2C);
    @(negedge clk);
    wrData = 8'h13;
    @(negedge clk);
    #0.5;
    check("R10 hold without wrEn", rdData, 8'h2C);
    setIn(3'b001, 1'b1, 1'b1);
    check("R10 pins hold", {6'b0, initLineN, dataDrvEn}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    testReset();
    testFollow();
    testForce();
    testInit();
    testReadback();
    testDir();
    testHold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule